// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block sits in front of the per-bank command sequencers of a single-channel DRAM controller with four banks. It accepts memory requests (bank, row, column and a write flag), keeps up to six of them in arrival order, and each cycle chooses at most one to hand to the sequencers. A per-bank ready input tells the scheduler which banks can accept work. A table of open rows, one entry per bank, follows the open-page policy: whatever row the last granted request used stays open in that bank.

Two selection policies are available. In arrival-order mode the oldest request whose bank is ready wins. In row-hit-first mode, requests that hit the open row of a ready bank need only a column command, and they are preferred over any request that needs a row command. Age decides within each of those two classes. When a request leaves, the queue closes the gap and keeps the order of the rest.

Each bank's row tracker is a small state machine with two states, CLOSED and OPEN. Reset puts every bank in CLOSED. A grant to a CLOSED bank takes the ACTIVATE transition to OPEN and loads the row. A grant to an OPEN bank for a different row takes the REOPEN transition, which stays in OPEN and replaces the row. A grant for the same row takes the HIT transition and leaves the state unchanged.

Top module: `rq_sched`

## Requirements
- R1: The queue holds at most 6 requests. `req_ready` is 1 exactly while fewer than 6 are held. A request offered while `req_ready` is 0 is not stored.
- R2: Granting an entry removes it. The remaining entries keep their relative arrival order.
- R3: With `mode_frfcfs` = 0, the grant goes to the oldest queued request whose bank has `bank_ready` = 1.
- R4: With `mode_frfcfs` = 1, an eligible request that hits its bank's open row is granted before any older eligible request that misses. Among hits, the oldest wins.
- R5: With `mode_frfcfs` = 1 and no eligible hit, the oldest eligible request is granted, and it is reported with `grant_hit` = 0.
- R6: A request is eligible only while `bank_ready[bank]` = 1. When nothing is eligible, `grant_valid` is 0. When anything is eligible, `grant_valid` is 1.
- R7: A request to a ready bank is granted even when an older request waits for a bank that is not ready.
- R8: After reset all banks are CLOSED. A grant records its row as open in its bank. `grant_hit` is 1 only when the granted request's bank is OPEN with the same row.
- R9: A request accepted at a clock edge can be granted from the next cycle onward, never in its own cycle. A grant is removed at the edge that ends its cycle. The grant carries the request's bank, row, column and write flag unchanged.
- R10: `mode_frfcfs` is changed only while the queue is empty, and the policy it selects governs the requests queued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_frfcfs | input | 1 | 1 = row-hit-first, 0 = arrival order |
| req_valid | input | 1 | A request is offered |
| req_bank | input | 2 | Request bank |
| req_row | input | 14 | Request row |
| req_col | input | 10 | Request column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Queue has room; offer is taken at the edge |
| bank_ready | input | 4 | Per-bank ready to accept a command |
| grant_valid | output | 1 | A request is issued this cycle |
| grant_bank | output | 2 | Issued bank |
| grant_row | output | 14 | Issued row |
| grant_col | output | 10 | Issued column |
| grant_write | output | 1 | Issued write flag |
| grant_hit | output | 1 | 1 = bank already open on this row (column command only) |

## Verification
The bound checker checks these properties on every cycle:
- the occupancy bound and the refusal of offers while full;
- that a grant only goes to a ready bank, and that a grant is always made when some bank can take one;
- that in row-hit-first mode a miss is never granted while an eligible hit waits;
- that arrival-order mode picks the oldest eligible entry;
- that the open-row table holds the granted row in the cycle after the grant;
- that the mode stays stable while the queue is occupied.

Only the bench's scenarios can show the full grant sequences that follow from age and row-hit interplay across a batch of requests. The same holds for the one-cycle latency from acceptance to grant, the fields carried through unchanged, and the loss of a hit once another row replaces the open one.

// File: rtl/rq_sched_pkg.sv
package rq_sched_pkg;

    // Selection policy
    typedef enum logic {
        MODE_FCFS   = 1'b0,
        MODE_FRFCFS = 1'b1
    } sched_mode_e;

    // Per-bank row-buffer state
    typedef enum logic {
        BK_CLOSED = 1'b0,
        BK_OPEN   = 1'b1
    } bank_state_e;

endpackage

// File: rtl/rq_queue.sv
// Age-ordered request storage: slot 0 is the oldest. Removal shifts the
// younger entries down by one; an append lands just past the survivors.
module rq_queue #(
    parameter int DEPTH = 6,
    parameter int ENT_W = 27,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic [ENT_W-1:0]                push_ent,
    input  logic                            pop,
    input  logic [IDX_W-1:0]                pop_idx,
    output logic [DEPTH-1:0][ENT_W-1:0]     ents,
    output logic [DEPTH-1:0]                vld,
    output logic [CNT_W-1:0]                count
);

    logic [DEPTH-1:0][ENT_W-1:0] ent_q;
    logic [DEPTH-1:0][ENT_W-1:0] shifted;
    logic [DEPTH-1:0][ENT_W-1:0] ent_d;
    logic [CNT_W-1:0]            cnt_q;
    logic [CNT_W-1:0]            cnt_mid;
    logic [CNT_W-1:0]            cnt_d;

    assign cnt_mid = cnt_q - CNT_W'(pop);
    assign cnt_d   = cnt_mid + CNT_W'(push);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i < DEPTH - 1) begin : g_mid
            always_comb begin
                if (pop && (IDX_W'(i) >= pop_idx)) begin
                    shifted[i] = ent_q[i+1];
                end else begin
                    shifted[i] = ent_q[i];
                end
            end
        end else begin : g_top
            always_comb begin
                if (pop && (IDX_W'(i) >= pop_idx)) begin
                    shifted[i] = '0;
                end else begin
                    shifted[i] = ent_q[i];
                end
            end
        end

        always_comb begin
            if (push && (cnt_mid == CNT_W'(i))) begin
                ent_d[i] = push_ent;
            end else begin
                ent_d[i] = shifted[i];
            end
        end

        assign vld[i] = (CNT_W'(i) < cnt_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
            cnt_q <= '0;
        end else begin
            ent_q <= ent_d;
            cnt_q <= cnt_d;
        end
    end

    assign ents  = ent_q;
    assign count = cnt_q;

endmodule

// File: rtl/rq_bank_table.sv
// One two-state row tracker per bank (CLOSED / OPEN), open-page policy.
module rq_bank_table
    import rq_sched_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int ROW_W = 14,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         upd_valid,
    input  logic [BANK_W-1:0]            upd_bank,
    input  logic [ROW_W-1:0]             upd_row,
    output logic [NBANK-1:0]             open_mask,
    output logic [NBANK-1:0][ROW_W-1:0]  open_rows
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_state_e      st_q;
        bank_state_e      st_d;
        logic [ROW_W-1:0] row_q;
        logic [ROW_W-1:0] row_d;
        logic             sel;

        assign sel = upd_valid && (upd_bank == BANK_W'(b));

        // Next state: ACTIVATE, REOPEN or HIT
        always_comb begin
            st_d  = st_q;
            row_d = row_q;
            unique case (st_q)
                BK_CLOSED: begin
                    if (sel) begin
                        st_d  = BK_OPEN;     // ACTIVATE
                        row_d = upd_row;
                    end
                end
                BK_OPEN: begin
                    if (sel && (upd_row != row_q)) begin
                        row_d = upd_row;     // REOPEN
                    end                      // else HIT or idle
                end
            endcase
        end

        // State register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= BK_CLOSED;
                row_q <= '0;
            end else begin
                st_q  <= st_d;
                row_q <= row_d;
            end
        end

        // Outputs
        assign open_mask[b] = (st_q == BK_OPEN);
        assign open_rows[b] = row_q;
    end

endmodule

// File: rtl/rq_picker.sv
// Chooses one queue slot per cycle. Lower slot index = older request.
module rq_picker
    import rq_sched_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int NBANK = 4,
    parameter int ROW_W = 14,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  sched_mode_e                  mode,
    input  logic [DEPTH-1:0]             vld,
    input  logic [DEPTH-1:0][BANK_W-1:0] e_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]  e_row,
    input  logic [NBANK-1:0]             bank_ready,
    input  logic [NBANK-1:0]             open_mask,
    input  logic [NBANK-1:0][ROW_W-1:0]  open_rows,
    output logic                         pick_valid,
    output logic [IDX_W-1:0]             pick_idx,
    output logic                         pick_hit
);

    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] hit;
    logic [IDX_W-1:0] old_elig_idx;
    logic [IDX_W-1:0] old_hit_idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cls
        assign elig[i] = vld[i] && bank_ready[e_bank[i]];
        assign hit[i]  = elig[i] && open_mask[e_bank[i]]
                       && (open_rows[e_bank[i]] == e_row[i]);
    end

    // Oldest-first priority encoders for each class
    always_comb begin
        old_elig_idx = '0;
        old_hit_idx  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig[i]) old_elig_idx = IDX_W'(i);
            if (hit[i])  old_hit_idx  = IDX_W'(i);
        end
    end

    always_comb begin
        pick_valid = |elig;
        unique case (mode)
            MODE_FCFS:   pick_idx = old_elig_idx;
            MODE_FRFCFS: pick_idx = (|hit) ? old_hit_idx : old_elig_idx;
        endcase
        pick_hit = pick_valid && hit[pick_idx];
    end

endmodule

// File: rtl/rq_sched.sv
module rq_sched
    import rq_sched_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int NBANK = 4,
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ENT_W  = 1 + BANK_W + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_frfcfs,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    output logic              req_ready,
    input  logic [NBANK-1:0]  bank_ready,
    output logic              grant_valid,
    output logic [BANK_W-1:0] grant_bank,
    output logic [ROW_W-1:0]  grant_row,
    output logic [COL_W-1:0]  grant_col,
    output logic              grant_write,
    output logic              grant_hit
);

    localparam int ROW_LSB  = COL_W;
    localparam int BANK_LSB = COL_W + ROW_W;

    logic [DEPTH-1:0][ENT_W-1:0]  ents;
    logic [DEPTH-1:0]             q_vld;
    logic [CNT_W-1:0]             q_count;
    logic [DEPTH-1:0][BANK_W-1:0] e_bank;
    logic [DEPTH-1:0][ROW_W-1:0]  e_row;
    logic [NBANK-1:0]             open_mask;
    logic [NBANK-1:0][ROW_W-1:0]  open_rows;
    logic                         pick_valid;
    logic [IDX_W-1:0]             pick_idx;
    logic                         pick_hit;
    logic                         push;
    logic [ENT_W-1:0]             g_ent;
    sched_mode_e                  mode;

    assign mode      = sched_mode_e'(mode_frfcfs);
    assign req_ready = (q_count < CNT_W'(DEPTH));
    assign push      = req_valid && req_ready;

    rq_queue #(
        .DEPTH (DEPTH),
        .ENT_W (ENT_W)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent ({req_write, req_bank, req_row, req_col}),
        .pop      (pick_valid),
        .pop_idx  (pick_idx),
        .ents     (ents),
        .vld      (q_vld),
        .count    (q_count)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_unpack
        assign e_bank[i] = ents[i][BANK_LSB +: BANK_W];
        assign e_row[i]  = ents[i][ROW_LSB +: ROW_W];
    end

    rq_picker #(
        .DEPTH (DEPTH),
        .NBANK (NBANK),
        .ROW_W (ROW_W)
    ) u_pick (
        .mode       (mode),
        .vld        (q_vld),
        .e_bank     (e_bank),
        .e_row      (e_row),
        .bank_ready (bank_ready),
        .open_mask  (open_mask),
        .open_rows  (open_rows),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .pick_hit   (pick_hit)
    );

    assign g_ent       = ents[pick_idx];
    assign grant_valid = pick_valid;
    assign grant_col   = g_ent[COL_W-1:0];
    assign grant_row   = g_ent[ROW_LSB +: ROW_W];
    assign grant_bank  = g_ent[BANK_LSB +: BANK_W];
    assign grant_write = g_ent[ENT_W-1];
    assign grant_hit   = pick_hit;

    rq_bank_table #(
        .NBANK (NBANK),
        .ROW_W (ROW_W)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (pick_valid),
        .upd_bank  (grant_bank),
        .upd_row   (grant_row),
        .open_mask (open_mask),
        .open_rows (open_rows)
    );

endmodule

// File: rtl/rq_sched_chk.sv
module rq_sched_chk #(
    parameter int DEPTH  = 6,
    parameter int NBANK  = 4,
    parameter int ROW_W  = 14,
    parameter int BANK_W = 2,
    parameter int CNT_W  = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         mode_frfcfs,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic [NBANK-1:0]             bank_ready,
    input logic                         grant_valid,
    input logic [BANK_W-1:0]            grant_bank,
    input logic [ROW_W-1:0]             grant_row,
    input logic                         grant_hit,
    input logic [CNT_W-1:0]             q_count,
    input logic [DEPTH-1:0]             q_vld,
    input logic [DEPTH-1:0][BANK_W-1:0] e_bank,
    input logic [DEPTH-1:0][ROW_W-1:0]  e_row,
    input logic [NBANK-1:0]             open_mask,
    input logic [NBANK-1:0][ROW_W-1:0]  open_rows
);

    logic              any_elig;
    logic              any_elig_hit;
    logic [BANK_W-1:0] old_bank;
    logic [ROW_W-1:0]  old_row;
    logic              took;

    assign took = req_valid && req_ready;

    always_comb begin
        any_elig     = 1'b0;
        any_elig_hit = 1'b0;
        old_bank     = '0;
        old_row      = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (q_vld[i] && bank_ready[e_bank[i]]) begin
                any_elig = 1'b1;
                old_bank = e_bank[i];
                old_row  = e_row[i];
                if (open_mask[e_bank[i]] && open_rows[e_bank[i]] == e_row[i]) begin
                    any_elig_hit = 1'b1;
                end
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH)); // R1
    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(DEPTH)) |-> !req_ready); // R1
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !took) |=> (q_count == $past(q_count) - 1'b1)); // R2
    AST_FCFS_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !mode_frfcfs) |-> (grant_bank == old_bank && grant_row == old_row)); // R3
    AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && mode_frfcfs && any_elig_hit) |-> grant_hit); // R4
    AST_READY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> bank_ready[grant_bank]); // R6
    AST_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        any_elig |-> grant_valid); // R7
    AST_ROW_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> (open_mask[$past(grant_bank)]
                         && open_rows[$past(grant_bank)] == $past(grant_row))); // R8
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count != '0) |-> $stable(mode_frfcfs)); // R10

endmodule

bind rq_sched rq_sched_chk #(
    .DEPTH  (DEPTH),
    .NBANK  (NBANK),
    .ROW_W  (ROW_W),
    .BANK_W (BANK_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_frfcfs (mode_frfcfs),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .bank_ready  (bank_ready),
    .grant_valid (grant_valid),
    .grant_bank  (grant_bank),
    .grant_row   (grant_row),
    .grant_hit   (grant_hit),
    .q_count     (q_count),
    .q_vld       (q_vld),
    .e_bank      (e_bank),
    .e_row       (e_row),
    .open_mask   (open_mask),
    .open_rows   (open_rows)
);

// File: tb/sim_rq_sched.sv
`timescale 1ns/1ps
module sim_rq_sched;

    localparam int ROW_W = 14;
    localparam int COL_W = 10;
    localparam int NV    = 4;

    // Batch vectors: six requests queued while no bank is ready, then all
    // banks made ready; expected grant order (by arrival index) and hit flags.
    localparam logic       V_MODE [NV]    = '{1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [1:0] V_BANK [NV][6] = '{'{0,1,0,0,1,2}, '{0,1,0,0,1,2},
                                              '{0,0,0,0,0,0}, '{0,0,0,0,0,0}};
    localparam logic [3:0] V_ROW  [NV][6] = '{'{1,2,1,3,2,5}, '{1,2,1,3,2,5},
                                              '{7,8,7,8,7,8}, '{7,8,7,8,7,8}};
    localparam logic [2:0] V_ORD  [NV][6] = '{'{0,1,2,3,4,5}, '{0,2,1,4,3,5},
                                              '{0,2,4,1,3,5}, '{0,1,2,3,4,5}};
    localparam logic       V_HIT  [NV][6] = '{'{0,0,1,0,1,0}, '{0,1,0,1,0,0},
                                              '{0,1,1,0,1,1}, '{0,0,0,0,0,0}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_frfcfs = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              req_write = 1'b0;
    logic              req_ready;
    logic [3:0]        bank_ready = '0;
    logic              grant_valid;
    logic [1:0]        grant_bank;
    logic [ROW_W-1:0]  grant_row;
    logic [COL_W-1:0]  grant_col;
    logic              grant_write;
    logic              grant_hit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rq_sched u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_frfcfs (mode_frfcfs),
        .req_valid   (req_valid),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .req_col     (req_col),
        .req_write   (req_write),
        .req_ready   (req_ready),
        .bank_ready  (bank_ready),
        .grant_valid (grant_valid),
        .grant_bank  (grant_bank),
        .grant_row   (grant_row),
        .grant_col   (grant_col),
        .grant_write (grant_write),
        .grant_hit   (grant_hit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n       = 1'b0;
        req_valid   = 1'b0;
        bank_ready  = '0;
        mode_frfcfs = m;            // R10: changed only with the queue empty
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer one request for one clock edge.
    task automatic push(input int b, input int r, input int c);
        @(negedge clk);
        req_valid = 1'b1;
        req_bank  = 2'(b);
        req_row   = ROW_W'(r);
        req_col   = COL_W'(c);
        req_write = c[0];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // ---- table-driven batches ----
        for (int v = 0; v < NV; v++) begin
            do_reset(V_MODE[v]);
            for (int k = 0; k < 6; k++) push(V_BANK[v][k], V_ROW[v][k], k);
            @(negedge clk);
            req_valid  = 1'b0;
            bank_ready = 4'hF;
            #1;
            for (int k = 0; k < 6; k++) begin
                chk($sformatf("R2 R6 v%0d k%0d grant_valid", v, k), grant_valid, 1);
                if (V_MODE[v]) begin
                    chk($sformatf("R4 R5 R10 v%0d k%0d col", v, k), grant_col, V_ORD[v][k]);
                end else begin
                    chk($sformatf("R3 R10 v%0d k%0d col", v, k), grant_col, V_ORD[v][k]);
                end
                chk($sformatf("R8 v%0d k%0d hit", v, k), grant_hit, V_HIT[v][k]);
                @(negedge clk);
                #1;
            end
            chk($sformatf("R2 v%0d drained", v), grant_valid, 0);
        end

        // ---- reset state ----
        do_reset(1'b0);
        #1;
        chk("R1 reset req_ready", req_ready, 1);
        chk("R6 reset grant_valid", grant_valid, 0);

        // ---- full queue, refusal, no eligible bank ----
        for (int k = 0; k < 6; k++) push(3, 4, k);
        @(negedge clk);
        #1;
        chk("R1 full req_ready", req_ready, 0);
        chk("R6 full but bank not ready", grant_valid, 0);
        req_valid = 1'b1;           // seventh offer while full
        req_col   = COL_W'(6);
        @(negedge clk);
        req_valid  = 1'b0;
        bank_ready = 4'h8;
        #1;
        begin
            int ng;
            ng = 0;
            for (int k = 0; k < 7; k++) begin
                if (grant_valid) begin
                    chk($sformatf("R2 full drain order k%0d", k), grant_col, ng);
                    ng++;
                end
                @(negedge clk);
                #1;
            end
            chk("R1 refused offer not stored (grant count)", ng, 6);
        end

        // ---- bank independence ----
        do_reset(1'b0);
        push(0, 1, 0);
        push(1, 1, 1);
        @(negedge clk);
        req_valid  = 1'b0;
        bank_ready = 4'b0010;
        #1;
        chk("R7 younger to ready bank granted", grant_col, 1);
        chk("R7 granted bank", grant_bank, 1);
        @(negedge clk);
        #1;
        chk("R6 only unready bank waiting", grant_valid, 0);
        bank_ready = 4'b0001;
        #1;
        chk("R6 bank becomes ready", grant_col, 0);

        // ---- acceptance latency, fields, open-row tracking ----
        do_reset(1'b1);
        bank_ready = 4'hF;
        push(2, 9, 5);
        #1;
        chk("R9 not grantable in accept cycle", grant_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R9 grant next cycle", grant_valid, 1);
        chk("R9 column carried", grant_col, 5);
        chk("R9 row carried", grant_row, 9);
        chk("R9 write carried", grant_write, 1);
        chk("R8 closed bank after reset is a miss", grant_hit, 0);
        @(negedge clk);
        #1;
        chk("R9 removed after grant", grant_valid, 0);
        push(2, 9, 6);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R8 same row now a hit", grant_hit, 1);
        push(2, 10, 7);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R8 other row a miss", grant_hit, 0);
        push(2, 9, 8);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R8 replaced row no longer hits", grant_hit, 0);
        chk("R9 write flag clear", grant_write, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule